// File: doc/BRIEF.md
# Partitioned SIMD Saturating Adder

This block is a 64-bit adder whose single carry chain can be cut at lane edges. A 2-bit lane-size input splits the word into eight 8-bit lanes, four 16-bit lanes, two 32-bit lanes, or one 64-bit lane. All lanes run the same operation at the same time. A subtract control turns the operation into a difference. A signedness control chooses whether lane values are read as two's-complement or unsigned. A saturate control chooses what an overflowing lane returns: either the wrapped result or the nearest value the lane can hold.

Each lane computes its result with no carry from the lane below it. In signed mode, overflow uses the usual sign rule for add and subtract. In unsigned mode, overflow is a carry out on add or a borrow on subtract. The block reports overflow once per byte. Every byte of a lane shows that lane's flag, so software and downstream logic can read it with the same byte mask in every mode. The adder is combinational. A parameter adds a register stage on the outputs, and that stage is present by default.

Top module: `simd_sat_adder`

## Requirements
- R1: With lane size 00, every byte is an independent lane, and no carry or borrow crosses from one byte into the next.
- R2: Lane-size encoding: 00 gives 8-bit lanes, 01 gives 16-bit lanes, 10 gives 32-bit lanes, and 11 gives one 64-bit lane with no partitioning. Carries propagate inside a lane and stop at its upper edge.
- R3: With saturation off, each lane result equals a+b (or a-b) modulo 2 to the power of the lane width, in both signed and unsigned mode.
- R4: In signed add, a lane overflows only when both operands have the same sign and the result sign differs from it. Operands of opposite sign never overflow.
- R5: Subtract forms a + ~b + 1, with the +1 entering at the bottom of every lane. In signed subtract, a lane overflows only when the operand signs differ and the result sign differs from the first operand.
- R6: In signed mode with saturation on, an overflowing lane returns the largest positive lane value (0x7F, 0x7FFF, ...) when the first operand is non-negative, and the most negative lane value (0x80, 0x8000, ...) otherwise.
- R7: In unsigned add, a lane overflows when it produces a carry out of its top bit. With saturation on, the lane then returns all ones.
- R8: In unsigned subtract, a lane overflows when a is less than b (a borrow). With saturation on, the lane then returns zero.
- R9: ovf_o has one bit per byte. Bit k is the overflow flag of the lane that contains byte k. The flag is reported whether saturation is on or off.
- R10: With the output register on (the default), sum_o and ovf_o show the result of the inputs presented one clock earlier. A synchronous active-high reset clears both outputs to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset |
| a_i | input | 64 | First packed operand |
| b_i | input | 64 | Second packed operand |
| lane_sz_i | input | 2 | Lane size: 00 = 8, 01 = 16, 10 = 32, 11 = 64 bits |
| sub_i | input | 1 | 1 = a - b, 0 = a + b |
| sat_i | input | 1 | 1 = clamp overflowing lanes, 0 = wrap |
| sgn_i | input | 1 | 1 = signed lanes, 0 = unsigned lanes |
| sum_o | output | 64 | Packed lane results |
| ovf_o | output | 8 | Per-byte copy of the owning lane's overflow flag |

## Verification
In 8-bit lane mode, the bench runs every pair of byte operands under all eight combinations of subtract, saturate and signedness. For the wider lanes it runs pairs built from lane-edge values (0, 1, the signed extremes and their neighbours, all ones), plus pseudo-random words. Each check targets a specific way the design could go wrong:
- A carry that leaks across a lane cut corrupts the neighbouring lane by one.
- A subtract that injects its +1 only at bit 0 leaves every upper lane off by one.
- A signed clamp that keys off the result sign instead of the operand sign saturates to the wrong extreme.
- Mixing up borrow and carry in unsigned subtract flags and zeroes the wrong lanes.

// File: rtl/simd_pkg.sv
package simd_pkg;

    localparam int BYTE_W_DEF = 8;
    localparam int NUM_BYTES_DEF = 8;

    typedef enum logic [1:0] {
        LANE_8  = 2'b00,
        LANE_16 = 2'b01,
        LANE_32 = 2'b10,
        LANE_64 = 2'b11
    } lane_sz_e;

    typedef struct packed {
        logic sub;
        logic sat;
        logic sgn;
    } op_ctrl_t;

    // Per-byte carry and sign information handed from the adder to the clamp stage.
    typedef struct packed {
        logic cout;
        logic a_msb;
        logic b_msb;   // after the subtract inversion
        logic r_msb;
    } byte_tail_t;

    // Number of bytes in one lane, capped at the word size.
    function automatic int lane_bytes(input lane_sz_e sz, input int nb);
        int lb;
        lb = 1 << int'(sz);
        if (lb > nb) lb = nb;
        return lb;
    endfunction

endpackage

// File: rtl/simd_part_adder.sv
module simd_part_adder
    import simd_pkg::*;
#(
    parameter int NB = NUM_BYTES_DEF,
    parameter int BW = BYTE_W_DEF,
    localparam int DW = NB * BW
) (
    input  logic [DW-1:0]          a_i,
    input  logic [DW-1:0]          b_i,
    input  lane_sz_e               sz_i,
    input  logic                   sub_i,
    output logic [DW-1:0]          raw_o,
    output byte_tail_t [NB-1:0]    tail_o
);

    always_comb begin
        logic          carry;
        logic          cin;
        logic [BW-1:0] ab;
        logic [BW-1:0] bx;
        logic [BW:0]   s;
        int            lb;
        lb    = lane_bytes(sz_i, NB);
        carry = 1'b0;
        raw_o = '0;
        for (int k = 0; k < NB; k++) begin
            // A lane's lowest byte takes the subtract +1 instead of the neighbour's carry.
            cin = ((k % lb) == 0) ? sub_i : carry;
            ab  = a_i[k*BW +: BW];
            bx  = b_i[k*BW +: BW] ^ {BW{sub_i}};
            s   = {1'b0, ab} + {1'b0, bx} + {{BW{1'b0}}, cin};
            raw_o[k*BW +: BW] = s[BW-1:0];
            carry = s[BW];
            tail_o[k].cout  = s[BW];
            tail_o[k].a_msb = ab[BW-1];
            tail_o[k].b_msb = bx[BW-1];
            tail_o[k].r_msb = s[BW-1];
        end
    end

endmodule

// File: rtl/simd_sat_unit.sv
module simd_sat_unit
    import simd_pkg::*;
#(
    parameter int NB = NUM_BYTES_DEF,
    parameter int BW = BYTE_W_DEF,
    localparam int DW = NB * BW
) (
    input  logic [DW-1:0]          raw_i,
    input  byte_tail_t [NB-1:0]    tail_i,
    input  lane_sz_e               sz_i,
    input  op_ctrl_t               ctrl_i,
    output logic [DW-1:0]          res_o,
    output logic [NB-1:0]          ovf_o
);

    logic [NB-1:0] end_flag;

    // Overflow as seen from the top byte of any lane that could end there.
    always_comb begin
        for (int k = 0; k < NB; k++) begin
            if (ctrl_i.sgn)
                end_flag[k] = (tail_i[k].a_msb == tail_i[k].b_msb) &&
                              (tail_i[k].r_msb != tail_i[k].a_msb);
            else
                end_flag[k] = ctrl_i.sub ? ~tail_i[k].cout : tail_i[k].cout;
        end
    end

    always_comb begin
        int            lb;
        int            e;
        logic          pos;
        logic [BW-1:0] clamp;
        lb    = lane_bytes(sz_i, NB);
        res_o = '0;
        for (int k = 0; k < NB; k++) begin
            e   = k | (lb - 1);
            pos = ~tail_i[e].a_msb;
            if (ctrl_i.sgn) begin
                if (k == e) clamp = pos ? {1'b0, {(BW-1){1'b1}}} : {1'b1, {(BW-1){1'b0}}};
                else        clamp = pos ? {BW{1'b1}} : {BW{1'b0}};
            end else begin
                clamp = ctrl_i.sub ? {BW{1'b0}} : {BW{1'b1}};
            end
            ovf_o[k] = end_flag[e];
            res_o[k*BW +: BW] = (ctrl_i.sat && end_flag[e]) ? clamp : raw_i[k*BW +: BW];
        end
    end

endmodule

// File: rtl/simd_sat_adder.sv
module simd_sat_adder
    import simd_pkg::*;
#(
    parameter int NUM_BYTES = NUM_BYTES_DEF,
    parameter int BYTE_W    = BYTE_W_DEF,
    parameter bit REG_OUT   = 1'b1,
    localparam int DATA_W   = NUM_BYTES * BYTE_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [DATA_W-1:0]     a_i,
    input  logic [DATA_W-1:0]     b_i,
    input  logic [1:0]            lane_sz_i,
    input  logic                  sub_i,
    input  logic                  sat_i,
    input  logic                  sgn_i,
    output logic [DATA_W-1:0]     sum_o,
    output logic [NUM_BYTES-1:0]  ovf_o
);

    lane_sz_e                   sz;
    op_ctrl_t                   ctrl;
    logic [DATA_W-1:0]          raw;
    byte_tail_t [NUM_BYTES-1:0] tail;
    logic [DATA_W-1:0]          res;
    logic [NUM_BYTES-1:0]       ovf;

    assign sz       = lane_sz_e'(lane_sz_i);
    assign ctrl.sub = sub_i;
    assign ctrl.sat = sat_i;
    assign ctrl.sgn = sgn_i;

    simd_part_adder #(.NB(NUM_BYTES), .BW(BYTE_W)) u_add (
        .a_i    (a_i),
        .b_i    (b_i),
        .sz_i   (sz),
        .sub_i  (sub_i),
        .raw_o  (raw),
        .tail_o (tail)
    );

    simd_sat_unit #(.NB(NUM_BYTES), .BW(BYTE_W)) u_sat (
        .raw_i  (raw),
        .tail_i (tail),
        .sz_i   (sz),
        .ctrl_i (ctrl),
        .res_o  (res),
        .ovf_o  (ovf)
    );

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    sum_o <= '0;
                    ovf_o <= '0;
                end else begin
                    sum_o <= res;
                    ovf_o <= ovf;
                end
            end
        end else begin : g_comb
            assign sum_o = res;
            assign ovf_o = ovf;
        end
    endgenerate

endmodule

// File: rtl/simd_sat_adder_chk.sv
module simd_sat_adder_chk #(
    parameter int NB = 8,
    parameter int DW = 64
) (
    input logic          clk,
    input logic          rst,
    input logic [DW-1:0] a_i,
    input logic [DW-1:0] b_i,
    input logic [1:0]    lane_sz_i,
    input logic          sub_i,
    input logic          sat_i,
    input logic          sgn_i,
    input logic [DW-1:0] sum_o,
    input logic [NB-1:0] ovf_o
);

    a_r10_reset_clears: assert property (@(posedge clk) rst |=> (sum_o == '0 && ovf_o == '0))
        else $error("R10 reset did not clear outputs");

    a_r3_add_zero: assert property (@(posedge clk) disable iff (rst)
        (!sub_i && b_i == '0) |=> (sum_o == $past(a_i) && ovf_o == '0))
        else $error("R3 adding zero changed the operand");

    a_r4_mixed_signs: assert property (@(posedge clk) disable iff (rst)
        (sgn_i && !sub_i && lane_sz_i == 2'b11 && a_i[DW-1] != b_i[DW-1]) |=> (ovf_o == '0))
        else $error("R4 mixed-sign add flagged overflow");

    a_r5_sub_same_sign: assert property (@(posedge clk) disable iff (rst)
        (sgn_i && sub_i && lane_sz_i == 2'b11 && a_i[DW-1] == b_i[DW-1]) |=> (ovf_o == '0))
        else $error("R5 same-sign subtract flagged overflow");

    a_r7_unsigned_ceiling: assert property (@(posedge clk) disable iff (rst)
        (!sgn_i && !sub_i && sat_i && lane_sz_i == 2'b11 && a_i > ~b_i) |=> (sum_o == '1))
        else $error("R7 unsigned carry did not clamp to all ones");

    a_r8_unsigned_floor: assert property (@(posedge clk) disable iff (rst)
        (!sgn_i && sub_i && sat_i && lane_sz_i == 2'b11 && a_i < b_i) |=> (sum_o == '0))
        else $error("R8 unsigned borrow did not clamp to zero");

    a_r9_single_lane_flag: assert property (@(posedge clk) disable iff (rst)
        (lane_sz_i == 2'b11) |=> (ovf_o == '0 || ovf_o == '1))
        else $error("R9 bytes of one lane disagree on the flag");

endmodule

bind simd_sat_adder simd_sat_adder_chk #(.NB(NUM_BYTES), .DW(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .a_i       (a_i),
    .b_i       (b_i),
    .lane_sz_i (lane_sz_i),
    .sub_i     (sub_i),
    .sat_i     (sat_i),
    .sgn_i     (sgn_i),
    .sum_o     (sum_o),
    .ovf_o     (ovf_o)
);

// File: tb/sim_simd_sat_adder.sv
`timescale 1ns/1ps
module sim_simd_sat_adder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] a_i = '0;
    logic [63:0] b_i = '0;
    logic [1:0]  lane_sz_i = 2'b00;
    logic        sub_i = 1'b0;
    logic        sat_i = 1'b0;
    logic        sgn_i = 1'b0;
    logic [63:0] sum_o;
    logic [7:0]  ovf_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    logic        pend = 1'b0;
    logic [63:0] pend_sum;
    logic [7:0]  pend_ovf;
    string       pend_tag;
    logic [63:0] lfsr = 64'h9E37_79B9_7F4A_7C15;

    always #2 clk = ~clk;   // 250 MHz

    simd_sat_adder u0 (
        .clk(clk), .rst(rst), .a_i(a_i), .b_i(b_i), .lane_sz_i(lane_sz_i),
        .sub_i(sub_i), .sat_i(sat_i), .sgn_i(sgn_i), .sum_o(sum_o), .ovf_o(ovf_o)
    );

    // Reference: exact lane arithmetic on wide signed integers, then range test.
    function automatic void model(input logic [63:0] a, input logic [63:0] b,
                                  input logic [1:0] code, input logic sub,
                                  input logic sat, input logic sgn,
                                  output logic [63:0] es, output logic [7:0] eo);
        int lw;
        int nl;
        logic [63:0] ones;
        lw = 8 << code;
        nl = 64 / lw;
        ones = (lw == 64) ? '1 : ((64'd1 << lw) - 64'd1);
        es = '0;
        eo = '0;
        for (int l = 0; l < nl; l++) begin
            logic [63:0] va;
            logic [63:0] vb;
            logic signed [71:0] ea;
            logic signed [71:0] eb;
            logic signed [71:0] r;
            logic signed [71:0] mx;
            logic signed [71:0] mn;
            logic ov;
            va = (a >> (l * lw)) & ones;
            vb = (b >> (l * lw)) & ones;
            ea = $signed({8'd0, va});
            eb = $signed({8'd0, vb});
            if (sgn && va[lw-1]) ea = ea - (72'sd1 <<< lw);
            if (sgn && vb[lw-1]) eb = eb - (72'sd1 <<< lw);
            mx = sgn ? $signed({8'd0, ones >> 1}) : $signed({8'd0, ones});
            mn = sgn ? (-mx - 72'sd1) : 72'sd0;
            r  = sub ? (ea - eb) : (ea + eb);
            ov = (r > mx) || (r < mn);
            if (sat && ov) r = (r > mx) ? mx : mn;
            es = es | ((r[63:0] & ones) << (l * lw));
            if (ov)
                for (int k = l * lw / 8; k < (l + 1) * lw / 8; k++) eo[k] = 1'b1;
        end
    endfunction

    function automatic logic [63:0] corner(input int idx, input int lw);
        logic [63:0] ones;
        logic [63:0] smax;
        ones = (lw == 64) ? '1 : ((64'd1 << lw) - 64'd1);
        smax = ones >> 1;
        case (idx)
            0: return 64'd0;
            1: return 64'd1;
            2: return 64'd2;
            3: return smax - 64'd1;
            4: return smax;
            5: return smax + 64'd1;
            6: return smax + 64'd2;
            7: return ones;
            default: return ones - 64'd1;
        endcase
    endfunction

    task automatic compare();
        checks++;
        if (sum_o !== pend_sum || ovf_o !== pend_ovf) begin
            errors++;
            $display("FAIL %s: sum=%h ovf=%b expected sum=%h ovf=%b",
                     pend_tag, sum_o, ovf_o, pend_sum, pend_ovf);
        end
    endtask

    // Checks the previous vector (registered one cycle), then drives a new one.
    task automatic drive(input logic [63:0] a, input logic [63:0] b, input logic [1:0] code,
                         input logic sub, input logic sat, input logic sgn, input string tag);
        @(negedge clk);
        if (pend) compare();
        a_i = a; b_i = b; lane_sz_i = code; sub_i = sub; sat_i = sat; sgn_i = sgn;
        model(a, b, code, sub, sat, sgn, pend_sum, pend_ovf);
        pend_tag = tag;
        pend = 1'b1;
    endtask

    task automatic flush();
        @(negedge clk);
        if (pend) compare();
        pend = 1'b0;
    endtask

    function automatic string mode_tag(input logic sub, input logic sat, input logic sgn);
        if (!sat) return sub ? "R5/R3 wrap" : "R3 wrap";
        if (sgn)  return sub ? "R5/R6 signed clamp" : "R4/R6 signed clamp";
        return sub ? "R8 unsigned floor" : "R7 unsigned ceiling";
    endfunction

    task automatic next_rand();
        lfsr = lfsr ^ (lfsr << 13);
        lfsr = lfsr ^ (lfsr >> 7);
        lfsr = lfsr ^ (lfsr << 17);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000 && !done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: cycles=%0d expected completion", cycles);
            finish_run();
        end
    end

    initial begin
        // R10: outputs cleared while reset is held, even with live inputs.
        a_i = '1; b_i = '1;
        repeat (3) @(negedge clk);
        checks++;
        if (sum_o !== '0 || ovf_o !== '0) begin
            errors++;
            $display("FAIL R10 reset: sum=%h ovf=%b expected sum=0 ovf=0", sum_o, ovf_o);
        end
        rst = 1'b0;

        // Directed vectors.
        drive(64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, 2'b00, 0, 0, 0, "R1 no byte carry");
        drive(64'h0000_0000_0000_0000, 64'h0101_0101_0101_0101, 2'b00, 1, 0, 0, "R1 no byte borrow");
        drive(64'h0000_0000_FFFF_FFFF, 64'h1, 2'b11, 0, 0, 0, "R2 64-bit carry crosses");
        drive(64'h0000_0000_FFFF_FFFF, 64'h1, 2'b10, 0, 0, 0, "R2 32-bit cut");
        drive(64'h0000_FFFF_0000_FFFF, 64'h0000_0001_0000_0001, 2'b01, 0, 1, 0, "R2/R7 16-bit lanes");
        drive(64'h7F7F_7F7F_8080_8080, 64'h0101_0101_FFFF_FFFF, 2'b00, 0, 1, 1, "R6 both extremes");
        drive(64'h7FFF_FFFF_8000_0000, 64'hFFFF_FFFF_0000_0001, 2'b10, 1, 1, 1, "R5/R6 sub clamp");
        drive(64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0, 2'b00, 1, 0, 1, "R5 lane +1 per byte");
        drive(64'h0005_0003_0100_0000, 64'h0006_0002_0001_0001, 2'b01, 1, 1, 0, "R8/R9 borrow per lane");
        drive(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 2'b11, 0, 0, 1, "R9 flag on every byte");

        // R1/R3..R8: exhaustive byte pairs, eight pairs per word, all modes.
        for (int m = 0; m < 8; m++) begin
            for (int i = 0; i < 8192; i++) begin
                logic [63:0] a;
                logic [63:0] b;
                for (int l = 0; l < 8; l++) begin
                    logic [15:0] p;
                    p = 16'(i * 8 + l);
                    a[l*8 +: 8] = p[15:8];
                    b[l*8 +: 8] = p[7:0];
                end
                drive(a, b, 2'b00, m[2], m[1], m[0], mode_tag(m[2], m[1], m[0]));
            end
        end

        // R2..R9: lane-edge pairs and random words for the wider lanes.
        for (int c = 1; c < 4; c++) begin
            for (int m = 0; m < 8; m++) begin
                int lw;
                int nl;
                lw = 8 << c;
                nl = 64 / lw;
                for (int j = 0; j < 81; j++) begin
                    logic [63:0] a;
                    logic [63:0] b;
                    a = '0; b = '0;
                    for (int l = 0; l < nl; l++) begin
                        int q;
                        q = (j + l * 7) % 81;
                        a = a | (corner(q / 9, lw) << (l * lw));
                        b = b | (corner(q % 9, lw) << (l * lw));
                    end
                    drive(a, b, 2'(c), m[2], m[1], m[0], mode_tag(m[2], m[1], m[0]));
                end
                for (int j = 0; j < 300; j++) begin
                    logic [63:0] a;
                    next_rand();
                    a = lfsr;
                    next_rand();
                    drive(a, lfsr, 2'(c), m[2], m[1], m[0], mode_tag(m[2], m[1], m[0]));
                end
            end
        end
        flush();

        // R10: reset mid-run clears a nonzero result.
        drive(64'h1111_1111_1111_1111, 64'h2222_2222_2222_2222, 2'b00, 0, 0, 0, "R10 latency");
        flush();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        checks++;
        if (sum_o !== '0 || ovf_o !== '0) begin
            errors++;
            $display("FAIL R10 mid-run reset: sum=%h ovf=%b expected sum=0 ovf=0", sum_o, ovf_o);
        end
        rst = 1'b0;
        finish_run();
    end

endmodule